// File: doc/BRIEF.md
# USB CRC5 / CRC16 Engine

This block computes the two check codes that USB packets carry: the 5-bit code that protects token fields and the 16-bit code that protects data payloads. A strobe on `start` selects the code and preloads the register with all ones. After that, each `din_valid` strobe absorbs between zero and eight bits of `din`, least significant bit first. All of those bits are handled in one clock cycle. Because the number of bits per strobe is programmable, the engine can take a token's address and endpoint bits (eight plus three), a whole byte stream, or single bits from a serializer.

The complemented check value is always present on `crc_out`. It is also split into the byte that goes on the wire first and the byte that follows it. On the receive side, the transmitted check bits are fed through the engine after the payload. `check_ok` then reports whether the register has reached the fixed value that an error-free packet leaves behind.

All outputs come from registers. An output reflects a strobe starting in the cycle after the clock edge that sampled it.

Top module: `ucrc_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, the register holds 16'hFFFF in 16-bit mode, so `crc_out` reads 16'h0000 and `check_ok` reads 0.
- R2: A `start` strobe without `din_valid` latches `mode_sel` (1 = 16-bit code, 0 = 5-bit code) and preloads 16'hFFFF or 5'h1F. From the next cycle `crc_out` reads 0.
- R3: In 16-bit mode each bit is processed LSB first. The bit is XORed with register bit 0, the register shifts right by one, and when that XOR was 1 the constant 16'hA001 is XORed in. `crc_out` is the bitwise complement of the register. The bytes 00 01 02 03 give `crc_out` = 16'h7AEF.
- R4: In 5-bit mode the same bit step uses the constant 5'h14 on a 5-bit register. `crc_out[4:0]` is the complement of the register and `crc_out[15:5]` is zero.
- R5: A `din_valid` strobe processes only `din` bits 0 through `din_cnt`-1. A count of 0 leaves the register unchanged, and any count above 8 processes all eight bits.
- R6: Feeding a byte with a count of 8 gives the same result as feeding its eight bits one per strobe, LSB first, with a count of 1 and each bit placed in `din[0]`.
- R7: `tx_first` equals `crc_out[7:0]` and `tx_second` equals `crc_out[15:8]`. This is the order of transmission, and `tx_second` is zero in 5-bit mode.
- R8: `check_ok` is 1 exactly when the register equals 16'hB001 in 16-bit mode or 5'h06 in 5-bit mode. This holds after a payload followed by its own complemented check bits, sent LSB first.
- R9: When `start` and `din_valid` arrive together, the preload is applied first and the data of that strobe is then absorbed.
- R10: When neither `start` nor `din_valid` is asserted, the outputs hold. Changes of `mode_sel` between `start` strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Code selection sampled on `start`: 1 = 16-bit, 0 = 5-bit |
| start | input | 1 | Preload strobe |
| din_valid | input | 1 | Data strobe |
| din | input | DATA_W (8) | Data bits, bit 0 first |
| din_cnt | input | CNT_W (4) | Number of `din` bits to absorb |
| crc_out | output | 16 | Complemented check value |
| tx_first | output | 8 | Check byte transmitted first |
| tx_second | output | 8 | Check byte transmitted second |
| check_ok | output | 1 | Register equals the error-free residual |

## Verification
Some properties are checked by assertions on every cycle. A preload reads back as zero, the outputs hold when idle, a preload combined with an empty data strobe still reads zero, and `check_ok` only ever appears with one of the two complemented residual values. The polynomial arithmetic, bit ordering, count clamping, the equivalence of byte-wide and bit-serial feeding, and the independence from mode changes in mid-packet can only be shown by the bench. It compares random and directed packets against its own bit-serial model, including the known 16-bit vector and round trips that append the computed check bits.

// File: rtl/ucrc_pkg.sv
package ucrc_pkg;

   typedef enum logic {
      CRC_M5  = 1'b0,
      CRC_M16 = 1'b1
   } crc_mode_e;

   localparam int REG_W  = 16;
   localparam int SHORT_W = 5;
   localparam int BYTE_W = 8;

   localparam logic [REG_W-1:0] POLY16 = 16'hA001;
   localparam logic [REG_W-1:0] SEED16 = 16'hFFFF;
   localparam logic [REG_W-1:0] RES16  = 16'hB001;
   localparam logic [REG_W-1:0] POLY5  = 16'h0014;
   localparam logic [REG_W-1:0] SEED5  = 16'h001F;
   localparam logic [REG_W-1:0] RES5   = 16'h0006;

   function automatic logic [REG_W-1:0] seed_of(crc_mode_e m);
      return (m == CRC_M16) ? SEED16 : SEED5;
   endfunction

   function automatic logic [REG_W-1:0] poly_of(crc_mode_e m);
      return (m == CRC_M16) ? POLY16 : POLY5;
   endfunction

   function automatic logic [REG_W-1:0] width_mask(crc_mode_e m);
      return (m == CRC_M16) ? {REG_W{1'b1}} : REG_W'((1 << SHORT_W) - 1);
   endfunction

endpackage

// File: rtl/ucrc_step.sv
module ucrc_step
   import ucrc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic [REG_W-1:0]  base,
   input  logic [REG_W-1:0]  poly,
   input  logic [DATA_W-1:0] data,
   input  logic [CNT_W-1:0]  cnt,
   output logic [REG_W-1:0]  nxt
);

   logic [DATA_W:0][REG_W-1:0] chain;

   assign chain[0] = base;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic             fb;
      logic [REG_W-1:0] shifted;
      assign fb      = chain[i][0] ^ data[i];
      assign shifted = {1'b0, chain[i][REG_W-1:1]} ^ (fb ? poly : '0);
      assign chain[i+1] = (CNT_W'(i) < cnt) ? shifted : chain[i];
   end

   assign nxt = chain[DATA_W];

endmodule

// File: rtl/ucrc_state.sv
module ucrc_state
   import ucrc_pkg::*;
#(
   parameter bit ENABLE_CRC5 = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             din_valid,
   input  crc_mode_e        mode_in,
   input  logic [REG_W-1:0] nxt,
   output logic [REG_W-1:0] base,
   output crc_mode_e        mode_eff,
   output logic [REG_W-1:0] crc_q,
   output crc_mode_e        mode_q
);

   crc_mode_e mode_req;

   if (ENABLE_CRC5) begin : g_dual
      assign mode_req = mode_in;
   end else begin : g_wide_only
      crc_mode_e unused_mode;
      assign unused_mode = mode_in;
      assign mode_req    = CRC_M16;
   end

   assign mode_eff = start ? mode_req : mode_q;
   assign base     = start ? seed_of(mode_req) : crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q  <= SEED16;
         mode_q <= CRC_M16;
      end else begin
         if (start) mode_q <= mode_req;
         if (start || din_valid) crc_q <= din_valid ? nxt : base;
      end
   end

endmodule

// File: rtl/ucrc_out.sv
module ucrc_out
   import ucrc_pkg::*;
(
   input  logic              [REG_W-1:0]  crc_q,
   input  crc_mode_e                      mode_q,
   output logic              [REG_W-1:0]  crc_out,
   output logic              [BYTE_W-1:0] tx_first,
   output logic              [BYTE_W-1:0] tx_second,
   output logic                           check_ok
);

   localparam logic [REG_W-1:0] RES_W16 = RES16;
   localparam logic [REG_W-1:0] RES_W5  = RES5;

   logic [REG_W-1:0] masked;

   assign masked    = crc_q & width_mask(mode_q);
   assign crc_out   = ~crc_q & width_mask(mode_q);
   assign tx_first  = crc_out[BYTE_W-1:0];
   assign tx_second = crc_out[2*BYTE_W-1:BYTE_W];
   assign check_ok  = (mode_q == CRC_M16) ? (masked == RES_W16) : (masked == RES_W5);

endmodule

// File: rtl/ucrc_unit.sv
module ucrc_unit
   import ucrc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit ENABLE_CRC5 = 1'b1,
   localparam int CNT_W      = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_sel,
   input  logic              start,
   input  logic              din_valid,
   input  logic [DATA_W-1:0] din,
   input  logic [CNT_W-1:0]  din_cnt,
   output logic [15:0]       crc_out,
   output logic [7:0]        tx_first,
   output logic [7:0]        tx_second,
   output logic              check_ok
);

   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
      $error("ucrc_unit: DATA_W must lie between 1 and 64");
   end
   if (REG_W != 2 * BYTE_W) begin : g_bad_reg
      $error("ucrc_unit: register must be two bytes wide");
   end

   logic [REG_W-1:0] base;
   logic [REG_W-1:0] nxt;
   logic [REG_W-1:0] crc_q;
   crc_mode_e        mode_eff;
   crc_mode_e        mode_q;

   ucrc_state #(.ENABLE_CRC5(ENABLE_CRC5)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .din_valid (din_valid),
      .mode_in   (crc_mode_e'(mode_sel)),
      .nxt       (nxt),
      .base      (base),
      .mode_eff  (mode_eff),
      .crc_q     (crc_q),
      .mode_q    (mode_q)
   );

   ucrc_step #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_step (
      .base (base),
      .poly (poly_of(mode_eff)),
      .data (din),
      .cnt  (din_cnt),
      .nxt  (nxt)
   );

   ucrc_out u_out (
      .crc_q     (crc_q),
      .mode_q    (mode_q),
      .crc_out   (crc_out),
      .tx_first  (tx_first),
      .tx_second (tx_second),
      .check_ok  (check_ok)
   );

endmodule

// File: rtl/ucrc_chk.sv
module ucrc_chk #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             din_valid,
   input logic [CNT_W-1:0] din_cnt,
   input logic [15:0]      crc_out,
   input logic             check_ok
);

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (crc_out == 16'h0000 && !check_ok));

   p_preload_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !din_valid) |=> (crc_out == 16'h0000 && !check_ok));

   p_start_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && din_valid && din_cnt == '0) |=> (crc_out == 16'h0000));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && (!din_valid || din_cnt == '0)) |=> ($stable(crc_out) && $stable(check_ok)));

   p_ok_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
      check_ok |-> (crc_out == 16'h4FFE || crc_out == 16'h0019));

endmodule

bind ucrc_unit ucrc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .din_valid (din_valid),
   .din_cnt   (din_cnt),
   .crc_out   (crc_out),
   .check_ok  (check_ok)
);

// File: tb/sim_ucrc_unit.sv
module sim_ucrc_unit;

   localparam int CLK_PER = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_sel = 1'b1;
   logic       start = 1'b0;
   logic       din_valid = 1'b0;
   logic [7:0] din = '0;
   logic [3:0] din_cnt = '0;
   logic [15:0] crc_out;
   logic [7:0]  tx_first;
   logic [7:0]  tx_second;
   logic        check_ok;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [15:0] m_st = 16'hFFFF;
   bit          m_md = 1'b1;

   always #(CLK_PER/2) clk = ~clk;

   ucrc_unit u0 (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .start(start),
      .din_valid(din_valid), .din(din), .din_cnt(din_cnt),
      .crc_out(crc_out), .tx_first(tx_first), .tx_second(tx_second),
      .check_ok(check_ok)
   );

   function automatic logic [15:0] m_step(logic [15:0] s, bit md, logic [7:0] d, int n);
      logic [15:0] p = md ? 16'hA001 : 16'h0014;
      for (int i = 0; i < 8; i++) begin
         if (i < n) begin
            logic fb = s[0] ^ d[i];
            s = s >> 1;
            if (fb) s = s ^ p;
         end
      end
      return s;
   endfunction

   function automatic logic [15:0] exp_out();
      return m_md ? ~m_st : {11'b0, ~m_st[4:0]};
   endfunction

   function automatic bit exp_ok();
      return m_md ? (m_st == 16'hB001) : (m_st[4:0] == 5'h06);
   endfunction

   task automatic chk(bit cond, string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic chk_all(string tag);
      chk(crc_out == exp_out(), {tag, " crc_out"}, 32'(crc_out), 32'(exp_out()));
      chk(tx_first == exp_out()[7:0] && tx_second == exp_out()[15:8], {tag, " R7 byte order"},
          {16'h0, tx_second, tx_first}, 32'(exp_out()));
      chk(check_ok == exp_ok(), {tag, " R8 check_ok"}, 32'(check_ok), 32'(exp_ok()));
   endtask

   task automatic push(bit st, bit vld, bit md, logic [7:0] d, int n);
      @(negedge clk);
      start = st; din_valid = vld; mode_sel = md; din = d; din_cnt = 4'(n);
      @(negedge clk);
      start = 1'b0; din_valid = 1'b0;
      if (st) begin m_md = md; m_st = md ? 16'hFFFF : 16'h001F; end
      if (vld) m_st = m_step(m_st, m_md, d, n > 8 ? 8 : n);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PER * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] saved;
      logic [7:0]  bytes [4];
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(crc_out == 16'h0 && !check_ok, "R1 reset state", {15'h0, check_ok, crc_out}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(crc_out == 16'h0 && !check_ok, "R1 after release", {15'h0, check_ok, crc_out}, 32'h0);

      // R2 / R3 known vector
      push(1, 0, 1, 8'h00, 0);
      chk(crc_out == 16'h0, "R2 preload", 32'(crc_out), 32'h0);
      for (int i = 0; i < 4; i++) push(0, 1, 1, 8'(i), 8);
      chk(crc_out == 16'h7AEF, "R3 vector 00010203", 32'(crc_out), 32'h7AEF);
      chk(tx_first == 8'hEF && tx_second == 8'h7A, "R7 EF then 7A",
          {16'h0, tx_second, tx_first}, 32'h7AEF);
      chk_all("R3");

      // R8 round trip on the vector
      saved = crc_out;
      push(0, 1, 1, saved[7:0], 8);
      push(0, 1, 1, saved[15:8], 8);
      chk(check_ok == 1'b1, "R8 vector residual", 32'(check_ok), 32'h1);

      // R4 token: 8 + 3 bits
      push(1, 0, 0, 8'h00, 0);
      chk(crc_out == 16'h0, "R2 preload 5-bit", 32'(crc_out), 32'h0);
      push(0, 1, 0, 8'h3A, 8);
      push(0, 1, 0, 8'hF5, 3);
      chk(crc_out[15:5] == 11'h0, "R4 upper zero", 32'(crc_out), 32'(exp_out()));
      chk_all("R4 token");
      saved = crc_out;
      push(0, 1, 0, saved[7:0], 5);
      chk(check_ok == 1'b1, "R8 token residual", 32'(check_ok), 32'h1);

      // R5 count 0 and count above 8
      push(1, 1, 1, 8'hA5, 8);
      saved = crc_out;
      push(0, 1, 1, 8'h5C, 0);
      chk(crc_out == saved, "R5 count zero", 32'(crc_out), 32'(saved));
      push(0, 1, 1, 8'h5C, 13);
      chk_all("R5 clamp");

      // R9 start with data
      push(1, 1, 1, 8'h42, 8);
      chk(crc_out == ~m_step(16'hFFFF, 1, 8'h42, 8), "R9 start+data",
          32'(crc_out), 32'(~m_step(16'hFFFF, 1, 8'h42, 8)));

      // R6 byte vs bit-serial
      for (int i = 0; i < 4; i++) bytes[i] = 8'($urandom);
      push(1, 0, 1, 8'h0, 0);
      for (int i = 0; i < 4; i++) push(0, 1, 1, bytes[i], 8);
      saved = crc_out;
      push(1, 0, 1, 8'h0, 0);
      for (int i = 0; i < 4; i++)
         for (int b = 0; b < 8; b++) push(0, 1, 1, {7'($urandom), bytes[i][b]}, 1);
      chk(crc_out == saved, "R6 bitwise equals bytewise", 32'(crc_out), 32'(saved));

      // R10 mode change mid-packet ignored, idle hold
      push(1, 0, 1, 8'h0, 0);
      push(0, 1, 0, 8'h99, 8);
      push(0, 1, 0, 8'h17, 8);
      chk_all("R10 mode change");
      saved = crc_out;
      @(negedge clk); mode_sel = 1'b0; din = 8'hFF; din_cnt = 4'd8;
      repeat (3) @(negedge clk);
      chk(crc_out == saved, "R10 idle hold", 32'(crc_out), 32'(saved));

      // random packets
      for (int p = 0; p < 60; p++) begin
         bit md = 1'($urandom);
         int nb = 1 + int'($urandom % 6);
         bit sd = 1'($urandom);
         push(1, sd, md, 8'($urandom), 8);
         for (int k = 0; k < nb; k++) begin
            int c = ($urandom % 4 == 0) ? int'($urandom % 16) : 8;
            push(0, 1, 1'($urandom), 8'($urandom), c);
            chk_all(md ? "R3 random" : "R4 random");
         end
         saved = crc_out;
         if (md) begin
            push(0, 1, 0, saved[7:0], 8);
            push(0, 1, 0, saved[15:8], 8);
         end else begin
            push(0, 1, 1, saved[7:0], 5);
         end
         chk(check_ok == 1'b1, "R8 random residual", 32'(check_ok), 32'h1);
      end

      finish_run();
   end

endmodule